// File: doc/BRIEF.md
# Serial Output-Freeze Controller

This block lets a system stop and restart up to twelve running clock outputs one at a time. It does this over a two-wire serial link made of a data line and its own sample clock. A frame opens with a low start bit and then carries one enable bit per gated output. The receiver collects the whole frame in a shift register. It copies the frame into the active freeze mask only on the serial-clock rising edge that follows the last data bit. Each output clock then picks up its own mask bit through a two-flop synchronizer in its own domain. The gate samples that bit while the clock is low, so a gated output can only be cut or restored at one of its own natural edges and never produces a short pulse.

The clocks to be gated come in as inputs; this block does not generate them. The receiver is a three-state machine. RX_IDLE waits for a start bit: a sampled 1 keeps it in RX_IDLE, and a sampled 0 takes it to RX_SHIFT. RX_SHIFT collects twelve bits and moves to RX_COMMIT after the twelfth. RX_COMMIT loads the mask and samples the line once more. A 0 at that edge is the start bit of the next frame and leads back to RX_SHIFT; a 1 leads to RX_IDLE. Master reset forces RX_IDLE and a mask of all ones, so every output runs.

Top module: `frz_ctrl`

## Requirements
- R1: An active-low asynchronous reset loads an all-ones mask, and from the release of reset every gated output equals its input clock.
- R2: In RX_IDLE, a sampled 1 is ignored and the receiver stays in RX_IDLE; the first sampled 0 is taken as a start bit.
- R3: The twelve bits after a start bit go to output indices 0 to 11 in arrival order. Indices 0 to 3 are the first bank's outputs 0 to 3, 4 to 7 are the second bank's outputs 0 to 3, 8 to 10 are the third bank's outputs 1 to 3, and 11 is the sync output.
- R4: A mask bit of 0 holds its output low and a 1 lets the output follow its clock. The steady state is reached within four periods of that output's clock after the mask changes.
- R5: The active mask does not change while a frame is being received. A new frame takes effect on the serial-clock rising edge after its twelfth bit.
- R6: The bit sampled on that update edge starts the next frame if it is 0, with no idle gap, and sends the receiver to RX_IDLE if it is 1.
- R7: A gated output falls only at the same instant as a falling edge of its own clock, so freezing never shortens a high phase.
- R8: A gated output rises only at the same instant as a rising edge of its own clock, so unfreezing never produces a runt pulse.
- R9: Each mask bit passes through two flops clocked by the output clock and is then captured on that clock's falling edge. The gate enable therefore stays constant through every high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial sample clock; data is taken on its rising edge |
| rst_n | input | 1 | Active-low asynchronous master reset |
| ser_data | input | 1 | Serial freeze data, NRZ, one bit per ser_clk period |
| clk_in | input | 12 | Running clocks to be gated, one per output |
| clk_out | output | 12 | Gated clocks; a frozen output is held low |

## Verification
A fault in the receiver state shows up at clk_out. A lost or extra bit rotates the whole mask onto the wrong outputs, and a wrong exit from RX_COMMIT makes the next frame land one bit off. Either error appears a synchronizer delay plus at most one clock period after the update edge. An early mask load shows as an output stopping or starting during the frame, before the update edge. A gate that samples in the wrong phase shows at once as a gated edge that does not line up with an edge of its clock.

// File: rtl/frz_pkg.sv
package frz_pkg;

    // Receiver states of the serial freeze link
    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_COMMIT = 2'd2
    } rx_state_e;

    // Output index assignment; arrival order on the link equals index order
    localparam int IDX_BANKA_FIRST = 0;
    localparam int IDX_BANKB_FIRST = 4;
    localparam int IDX_BANKC_FIRST = 8;
    localparam int IDX_SYNC        = 11;

endpackage

// File: rtl/frz_rx.sv
module frz_rx
    import frz_pkg::*;
#(
    parameter int NBITS = 12
) (
    input  logic             ser_clk,
    input  logic             rst_n,
    input  logic             ser_data,
    output logic [NBITS-1:0] mask_o
);
    localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

    rx_state_e        state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [NBITS-1:0] shreg_q;
    logic [NBITS-1:0] mask_q;

    // State register
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   state_d = ser_data ? RX_IDLE : RX_SHIFT;
            RX_SHIFT:  state_d = (cnt_q == LAST) ? RX_COMMIT : RX_SHIFT;
            RX_COMMIT: state_d = ser_data ? RX_IDLE : RX_SHIFT;
            default:   state_d = RX_IDLE;
        endcase
    end

    // Datapath and outputs: bit counter, frame shifter, active mask
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '1;
            mask_q  <= '1;
        end else begin
            unique case (state_q)
                RX_IDLE: cnt_q <= '0;
                RX_SHIFT: begin
                    shreg_q <= {ser_data, shreg_q[NBITS-1:1]};
                    cnt_q   <= cnt_q + 1'b1;
                end
                RX_COMMIT: begin
                    mask_q <= shreg_q;
                    cnt_q  <= '0;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign mask_o = mask_q;

    assert_idle_hold_R2: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state_q == RX_IDLE && ser_data) |=> (state_q == RX_IDLE));

    assert_start_detect_R2: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state_q == RX_IDLE && !ser_data) |=> (state_q == RX_SHIFT && cnt_q == '0));

    assert_count_bound_R3: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state_q == RX_SHIFT) |-> (cnt_q <= LAST));

    assert_mask_deferred_R5: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (mask_q != $past(mask_q)) |-> ($past(state_q) == RX_COMMIT));

    assert_chain_R6: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state_q == RX_COMMIT) |=> (state_q == ($past(ser_data) ? RX_IDLE : RX_SHIFT)));

endmodule

// File: rtl/frz_gate.sv
module frz_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic run_i,
    output logic gclk_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_q;

    // Synchronizer in the output clock domain; reset value means running
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], run_i};
    end

    // Enable captured while the clock is low, held through the high phase
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= sync_q[SYNC_STAGES-1];
    end

    assign gclk_o = clk_i & en_q;

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            // A mask bit steady over three falling edges has reached the enable
            assert_enable_follows_R9: assert property (@(negedge clk_i) disable iff (!rst_n)
                ($past(run_i, 2) == run_i && $past(run_i) == run_i) |=> (en_q == $past(run_i)));
        end
    endgenerate

endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl #(
    parameter int NUM_OUT     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               ser_clk,
    input  logic               rst_n,
    input  logic               ser_data,
    input  logic [NUM_OUT-1:0] clk_in,
    output logic [NUM_OUT-1:0] clk_out
);
    logic [NUM_OUT-1:0] mask;

    frz_rx #(.NBITS(NUM_OUT)) u_rx (
        .ser_clk  (ser_clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .mask_o   (mask)
    );

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
            frz_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
                .clk_i  (clk_in[g]),
                .rst_n  (rst_n),
                .run_i  (mask[g]),
                .gclk_o (clk_out[g])
            );
        end
    endgenerate

endmodule

// File: tb/test_frz_ctrl.sv
`timescale 1ns/100ps
module test_frz_ctrl;
    localparam int N = 12;

    logic         ser_clk = 1'b0;
    logic         rst_n   = 1'b0;
    logic         ser_data = 1'b1;
    logic [N-1:0] clk_in;
    logic [N-1:0] clk_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";

    frz_ctrl i_frz_ctrl (
        .ser_clk  (ser_clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .clk_in   (clk_in),
        .clk_out  (clk_out)
    );

    // 125 MHz serial clock: edges on whole nanoseconds
    initial forever #4 ser_clk = ~ser_clk;

    // Output clocks: half period 3+k ns, edges on half nanoseconds
    for (genvar k = 0; k < N; k++) begin : g_ch
        logic    c = 1'b0;
        realtime last_r = 0.0;
        realtime last_f = 0.0;
        initial begin
            #0.5;
            forever #(3 + k) c = ~c;
        end
        assign clk_in[k] = c;
        always @(posedge c) last_r = $realtime;
        always @(negedge c) last_f = $realtime;
        // R8: gated rise coincides with a clock rise
        always @(posedge clk_out[k]) begin
            realtime t;
            t = $realtime;
            #0.1;
            n_checks++;
            if (last_r != t) begin
                n_fail++;
                $display("FAIL R8 ch%0d gated rise at %0t, expected a clock rise then (last rise %0t)", k, t, last_r);
            end
        end
        // R7: gated fall coincides with a clock fall
        always @(negedge clk_out[k]) begin
            realtime t;
            t = $realtime;
            #0.1;
            n_checks++;
            if (last_f != t) begin
                n_fail++;
                $display("FAIL R7 ch%0d gated fall at %0t, expected a clock fall then (last fall %0t)", k, t, last_f);
            end
        end
    end

    // Behavioural reference: receiver and expected mask
    int           m_state = 0;   // 0 idle, 1 collecting, 2 update
    int           m_cnt   = 0;
    logic [N-1:0] m_sh    = '1;
    logic [N-1:0] exp_run = '1;
    realtime      chg_t [N];

    initial for (int i = 0; i < N; i++) chg_t[i] = 0.0;

    always @(posedge ser_clk) begin
        if (rst_n) begin
            case (m_state)
                0: if (!ser_data) begin m_state = 1; m_cnt = 0; end
                1: begin
                    m_sh = {ser_data, m_sh[N-1:1]};
                    m_cnt++;
                    if (m_cnt == N) m_state = 2;
                end
                default: begin
                    for (int i = 0; i < N; i++)
                        if (exp_run[i] != m_sh[i]) chg_t[i] = $realtime;
                    exp_run = m_sh;
                    m_cnt   = 0;
                    m_state = ser_data ? 0 : 1;
                end
            endcase
        end
    end

    // Compare every serial clock, once each output has settled (R4 window)
    always @(negedge ser_clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                realtime settle;
                logic    want;
                settle = 8.0 * (3 + i) + 16.0;
                if ($realtime - chg_t[i] >= settle) begin
                    want = exp_run[i] ? clk_in[i] : 1'b0;
                    n_checks++;
                    if (clk_out[i] !== want) begin
                        n_fail++;
                        $display("FAIL %s ch%0d at %0t: clk_out=%b expected %b", tag, i, $realtime, clk_out[i], want);
                    end
                end
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge ser_clk);
        ser_data = b;
    endtask

    task automatic send_frame(input logic [N-1:0] v);
        send_bit(1'b0);
        for (int i = 0; i < N; i++) send_bit(v[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    logic done = 1'b0;

    initial begin
        // R1: reset state, all outputs running
        tag = "R1";
        repeat (5) @(negedge ser_clk);
        rst_n = 1'b1;
        idle(30);

        // R3: walking zero places each bit on its own index
        tag = "R3";
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] v;
            v = '1;
            v[i] = 1'b0;
            send_frame(v);
            idle(20);
        end

        // R4: polarity with several patterns
        tag = "R4";
        send_frame(12'h000); idle(20);
        send_frame(12'hFFF); idle(20);
        send_frame(12'hA5C); idle(20);
        send_frame(12'h3C6); idle(20);

        // R5: mask held through a slow frame with idle lead-in
        tag = "R5";
        idle(7);
        send_frame(12'h0F0); idle(20);

        // R6: back-to-back frames chained on the update edge
        tag = "R6";
        send_frame(12'h123);
        send_frame(12'hEDC);
        send_frame(12'h555);
        idle(20);

        // R2 and R6: update edge sees 1, receiver idles through ones
        tag = "R2";
        send_frame(12'h00F);
        idle(3);
        send_frame(12'hF0A);
        idle(25);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule